// File: doc/BRIEF.md
# CPU Status Latch and Bus Command Decoder

This block sits next to an 8-bit processor whose data bus carries a status byte during a sync strobe at the start of each machine cycle. When the sync input is high at a rising clock edge, the block stores that byte. It then combines the stored bits with the processor's read strobe (active high) and write strobe (active low). From these it produces five separate active-low bus commands: memory read, memory write, I/O read, I/O write and interrupt acknowledge.

During an interrupt-acknowledge read, the block drives a one-byte restart opcode onto the data bus. The opcode is built from a 3-bit vector number. While a DMA master owns the bus, every command is held inactive and the opcode driver is off. The command outputs are combinational from the stored status and the live strobes, so they follow the strobes with no added cycle.

Top module: `cpu_status_decoder`

## Requirements
- R1: The status register loads `status_i` at a rising clock edge where `sync_i` is high. Otherwise it keeps its value, whatever `status_i` does.
- R2: `mem_rd_no` is low exactly when `rd_i` is high, stored status bit 7 (memory read) is set and `dma_ack_i` is low.
- R3: `io_rd_no` is low exactly when `rd_i` is high, stored status bit 6 (input port) is set and `dma_ack_i` is low.
- R4: `int_ack_no` is low exactly when `rd_i` is high, stored status bit 0 (interrupt fetch) is set and `dma_ack_i` is low.
- R5: `mem_wr_no` is low exactly when `wr_ni` is low, stored status bits 4 and 0 are both clear and `dma_ack_i` is low. A write that carries bit 0 asserts no write command.
- R6: `io_wr_no` is low exactly when `wr_ni` is low, stored status bit 4 (output port) is set and `dma_ack_i` is low.
- R7: `data_oe_o` is high exactly while interrupt acknowledge is asserted. `data_o` then equals 8'b11_vvv_111, where vvv is `rst_vec_i`; otherwise `data_o` is 8'h00.
- R8: While `dma_ack_i` is high, all five commands are high and `data_oe_o` is low.
- R9: While `rst_ni` is low, all commands are high and `data_oe_o` is low. Reset clears the stored status to 8'h00.
- R10: Status bits 2 (stack), 3 (halt), 5 (opcode fetch) and 1 (read/write flag) do not change any command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| status_i | input | 8 | Processor data bus as seen by the latch |
| sync_i | input | 1 | Status-valid strobe, active high |
| rd_i | input | 1 | Processor read strobe, active high |
| wr_ni | input | 1 | Processor write strobe, active low |
| dma_ack_i | input | 1 | Bus granted to a DMA master |
| rst_vec_i | input | 3 | Restart vector number placed in the opcode |
| mem_rd_no | output | 1 | Memory read command, active low |
| mem_wr_no | output | 1 | Memory write command, active low |
| io_rd_no | output | 1 | I/O read command, active low |
| io_wr_no | output | 1 | I/O write command, active low |
| int_ack_no | output | 1 | Interrupt acknowledge command, active low |
| data_o | output | 8 | Restart opcode toward the data bus |
| data_oe_o | output | 1 | Enable for the data-bus driver |

## Verification
The stored status changes one rising edge after a sync cycle. The commands and the opcode follow the strobes, the DMA grant and the reset input combinationally, in the same cycle. The driver therefore loads status in a sync cycle and releases sync at the next falling edge. It then applies strobes and pushes the expected outputs, and the monitor compares them one time step later. That is well before the next rising edge, so a stale or early latch shows up directly. The hold case feeds a different byte on the bus with sync low for a full edge, then strobes to show that the earlier byte still decides the command.

// File: rtl/cpu_status_pkg.sv
package cpu_status_pkg;
  localparam int STAT_W = 8;
  localparam int VEC_W  = 3;

  // status bit positions, fixed by the processor
  localparam int SB_INTA = 0;
  localparam int SB_RD   = 1;
  localparam int SB_STK  = 2;
  localparam int SB_HALT = 3;
  localparam int SB_OUT  = 4;
  localparam int SB_M1   = 5;
  localparam int SB_INP  = 6;
  localparam int SB_MEMR = 7;

  typedef struct packed {
    logic mem_rd;
    logic mem_wr;
    logic io_rd;
    logic io_wr;
    logic int_ack;
  } cmd_t;
endpackage

// File: rtl/status_latch.sv
module status_latch #(
  parameter int W = cpu_status_pkg::STAT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sync_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (sync_i) q_o <= d_i;
  end

  // R1
  status_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_i |=> $stable(q_o));
  // R1
  status_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |=> (q_o == $past(d_i)));
endmodule

// File: rtl/cmd_decode.sv
module cmd_decode
  import cpu_status_pkg::*;
#(
  parameter int W = STAT_W
) (
  input  logic [W-1:0] stat_i,
  input  logic         rd_i,
  input  logic         wr_ni,
  input  logic         block_i,
  output cmd_t         cmd_o
);
  logic wr_act;
  assign wr_act = ~wr_ni;

  always_comb begin
    cmd_o = '0;
    if (!block_i) begin
      cmd_o.mem_rd  = rd_i & stat_i[SB_MEMR];
      cmd_o.io_rd   = rd_i & stat_i[SB_INP];
      cmd_o.int_ack = rd_i & stat_i[SB_INTA];
      cmd_o.io_wr   = wr_act & stat_i[SB_OUT];
      cmd_o.mem_wr  = wr_act & ~stat_i[SB_OUT] & ~stat_i[SB_INTA];
    end
  end
endmodule

// File: rtl/vector_drive.sv
module vector_drive #(
  parameter int VW = cpu_status_pkg::VEC_W,
  parameter int DW = cpu_status_pkg::STAT_W
) (
  input  logic          ack_i,
  input  logic [VW-1:0] vec_i,
  output logic [DW-1:0] data_o,
  output logic          oe_o
);
  localparam int LOW_W = 3;
  localparam int TOP_W = DW - VW - LOW_W;

  logic [DW-1:0] opcode;
  assign opcode = {{TOP_W{1'b1}}, vec_i, {LOW_W{1'b1}}};
  assign oe_o   = ack_i;
  assign data_o = ack_i ? opcode : '0;
endmodule

// File: rtl/cpu_status_decoder.sv
module cpu_status_decoder
  import cpu_status_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STAT_W-1:0] status_i,
  input  logic              sync_i,
  input  logic              rd_i,
  input  logic              wr_ni,
  input  logic              dma_ack_i,
  input  logic [VEC_W-1:0]  rst_vec_i,
  output logic              mem_rd_no,
  output logic              mem_wr_no,
  output logic              io_rd_no,
  output logic              io_wr_no,
  output logic              int_ack_no,
  output logic [STAT_W-1:0] data_o,
  output logic              data_oe_o
);
  logic [STAT_W-1:0] stat_q;
  cmd_t              cmd;
  logic              block;

  status_latch #(.W(STAT_W)) u_latch (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sync_i(sync_i),
    .d_i   (status_i),
    .q_o   (stat_q)
  );

  assign block = dma_ack_i | ~rst_ni;

  cmd_decode #(.W(STAT_W)) u_dec (
    .stat_i (stat_q),
    .rd_i   (rd_i),
    .wr_ni  (wr_ni),
    .block_i(block),
    .cmd_o  (cmd)
  );

  vector_drive #(.VW(VEC_W), .DW(STAT_W)) u_vec (
    .ack_i (cmd.int_ack),
    .vec_i (rst_vec_i),
    .data_o(data_o),
    .oe_o  (data_oe_o)
  );

  assign mem_rd_no  = ~cmd.mem_rd;
  assign mem_wr_no  = ~cmd.mem_wr;
  assign io_rd_no   = ~cmd.io_rd;
  assign io_wr_no   = ~cmd.io_wr;
  assign int_ack_no = ~cmd.int_ack;

  // R8
  dma_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_ack_i |-> (mem_rd_no && mem_wr_no && io_rd_no && io_wr_no && int_ack_no && !data_oe_o));
  // R7
  opcode_form_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> (!int_ack_no && data_o == {2'b11, rst_vec_i, 3'b111}));
  // R5
  wr_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_wr_no |-> mem_wr_no);
  // R4
  inta_needs_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !int_ack_no |-> rd_i);
endmodule

// File: tb/tb_cpu_status_decoder.sv
module tb_cpu_status_decoder;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] status_i = '0;
  logic       sync_i = 1'b0, rd_i = 1'b0, wr_ni = 1'b1, dma_ack_i = 1'b0;
  logic [2:0] rst_vec_i = '0;
  logic       mem_rd_no, mem_wr_no, io_rd_no, io_wr_no, int_ack_no, data_oe_o;
  logic [7:0] data_o;

  always #2 clk = ~clk;  // 250 MHz

  cpu_status_decoder dut (
    .clk_i(clk), .rst_ni(rst_ni), .status_i(status_i), .sync_i(sync_i),
    .rd_i(rd_i), .wr_ni(wr_ni), .dma_ack_i(dma_ack_i), .rst_vec_i(rst_vec_i),
    .mem_rd_no(mem_rd_no), .mem_wr_no(mem_wr_no), .io_rd_no(io_rd_no),
    .io_wr_no(io_wr_no), .int_ack_no(int_ack_no), .data_o(data_o), .data_oe_o(data_oe_o)
  );

  typedef struct {
    logic [13:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int    n_cmp = 0, n_bad = 0;
  bit    done = 0;
  event  smp_ev;
  logic [7:0] mdl_st = '0;

  // {mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, int_ack_n, oe, data}
  function automatic logic [13:0] model(input logic [7:0] st, input logic rd,
      input logic wrn, input logic dma, input logic rst_n, input logic [2:0] vec);
    logic blk, mr, mw, ir, iw, ia;
    blk = dma | ~rst_n;
    mr  = !blk && rd && st[7];
    ir  = !blk && rd && st[6];
    ia  = !blk && rd && st[0];
    iw  = !blk && !wrn && st[4];
    mw  = !blk && !wrn && !st[4] && !st[0];
    return {~mr, ~mw, ~ir, ~iw, ~ia, ia, ia ? {2'b11, vec, 3'b111} : 8'h00};
  endfunction

  task automatic load(input logic [7:0] st);
    @(negedge clk);
    rd_i = 0; wr_ni = 1; status_i = st; sync_i = 1;
    @(negedge clk);
    sync_i = 0; status_i = 8'h00;
    mdl_st = st;
  endtask

  task automatic strobe(input logic rd, input logic wrn, input logic dma,
                        input logic [2:0] vec, input string tag);
    item_t it;
    rd_i = rd; wr_ni = wrn; dma_ack_i = dma; rst_vec_i = vec;
    #1;
    it.exp = model(mdl_st, rd, wrn, dma, rst_ni, vec);
    it.tag = tag;
    q.push_back(it);
    -> smp_ev;
    #1;
    rd_i = 0; wr_ni = 1; dma_ack_i = 0;
  endtask

  initial begin : monitor
    item_t it;
    logic [13:0] got;
    forever begin
      @(smp_ev);
      it = q.pop_front();
      got = {mem_rd_no, mem_wr_no, io_rd_no, io_wr_no, int_ack_no, data_oe_o, data_o};
      n_cmp++;
      if (got !== it.exp) begin
        n_bad++;
        $display("FAIL %s: got %b expected %b", it.tag, got, it.exp);
      end
    end
  end

  initial begin : watchdog
    #400000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    // R9: inactive outputs during reset even with strobes active
    strobe(1, 0, 0, 3'd2, "R9 in reset");
    @(negedge clk); rst_ni = 1;
    @(negedge clk);
    mdl_st = 8'h00;
    strobe(1, 1, 0, 3'd0, "R9 cleared status, read");
    strobe(0, 0, 0, 3'd0, "R9 cleared status, write");
    load(8'hA2); strobe(1, 1, 0, 3'd0, "R2 fetch read R10 bit5");
    load(8'h86); strobe(1, 1, 0, 3'd0, "R2 stack read R10 bit2");
    load(8'h82); strobe(0, 1, 0, 3'd0, "R2 no strobe");
    load(8'h42); strobe(1, 1, 0, 3'd0, "R3 port read");
    load(8'h23); strobe(1, 1, 0, 3'd5, "R4 R7 vec5");
    strobe(1, 1, 0, 3'd0, "R7 vec0");
    strobe(1, 1, 0, 3'd7, "R7 vec7");
    load(8'h00); strobe(0, 0, 0, 3'd0, "R5 mem write");
    load(8'h04); strobe(0, 0, 0, 3'd0, "R5 stack write R10");
    load(8'h10); strobe(0, 0, 0, 3'd0, "R6 port write");
    load(8'h01); strobe(0, 0, 0, 3'd0, "R5 write with int bit");
    load(8'h8A); strobe(0, 1, 0, 3'd0, "R10 halt idle");
    load(8'h82); strobe(1, 1, 1, 3'd0, "R8 dma read");
    load(8'h23); strobe(1, 1, 1, 3'd3, "R8 dma inta");
    load(8'h00); strobe(0, 0, 1, 3'd0, "R8 dma write");
    // R1: bus changes with sync low must not reach the latch
    load(8'h42);
    @(negedge clk); status_i = 8'h81;
    @(negedge clk); status_i = 8'h00;
    strobe(1, 1, 0, 3'd0, "R1 hold io read");
    strobe(0, 0, 0, 3'd0, "R1 hold write");
    repeat (2) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule